// File: doc/BRIEF.md
# Network Controller Indirect Register Port

This block is the slave-side register file of a network controller. Software reaches four internal 16-bit registers through two accesses: a select write that picks the target, and a data access that reads or writes the picked register. Register 0 is the control and status word. It holds the command bits that start, stop and initialize the controller and demand a transmit poll, the interrupt enable, and seven sticky event flags. Each flag is set by a one-cycle pulse from the controller core and is cleared when software writes a one to it.

Registers 1 to 3 hold the initialization-block address, split into a 16-bit low half and a parameterised high part, and a 3-bit bus-configuration field. They accept writes only while the controller is stopped. The block drives a single interrupt line and one-cycle command pulses toward the controller core. It also presents the assembled address and the configuration field to the core as plain outputs.

Top module: `netctl_regport`

## Requirements
- R1: After reset, register 0 reads 0x0004 (only the stopped bit set), the select register is 0, registers 1 to 3 read zero, `stopped_o` is 1, and `irq_o` and all pulse outputs are 0.
- R2: A write with `sel_we_i` loads `wdata_i[1:0]` into the select register. `rdata_o` continuously shows the selected register. Register 1 is the address low 16 bits. Register 2 is the address high `ADDR_HI_W` bits, zero-extended. Register 3 is the 3-bit bus field (bit 2 byte swap, bit 1 address-latch style, bit 0 byte-control polarity), zero-extended. `iblk_addr_o` is {reg2, reg1} and `bus_cfg_o` is reg3.
- R3: Data writes to registers 1 to 3 take effect only while the stopped bit is set. At any other time they are ignored.
- R4: Register 0 bit positions, from bit 15 down to bit 0: ERR, BABL, CERR, MISS, MERR, RINT, TINT, IDON, INTR, INEA, RXON, TXON, TDMD, STOP, STRT, INIT.
- R5: Writing 1 to INIT sets the INIT bit and clears STOP. A later `init_done_i` pulse sets IDON, visible in the cycle after the pulse.
- R6: BABL, CERR, MISS, MERR, RINT, TINT and IDON are sticky, set by `babble_i`, `cerr_i`, `miss_i`, `merr_i`, `rx_done_i`, `tx_done_i` and `init_done_i`. A data write to register 0 clears each flag whose bit is written as 1 and leaves flags written as 0. An event arriving in the same cycle as its clear leaves the flag set.
- R7: INTR reads 1 whenever any of the seven flags is set. INEA is a plain read/write bit. `irq_o` is INTR AND INEA.
- R8: ERR reads as the OR of BABL, CERR, MISS and MERR and is not writable.
- R9: Writing 1 to STRT sets STRT, RXON and TXON and clears STOP. Writing 1 to TDMD while not stopped produces a transmit-poll pulse; TDMD always reads 0. Writing 0 to INIT, STRT, TDMD or STOP changes nothing.
- R10: Writing 1 to STOP takes precedence over every other bit of the same write. It sets STOP, clears INEA, RXON, TXON, STRT, INIT and all seven flags, and returns the select register to 0. Event inputs are ignored while stopped.
- R11: `init_pulse_o`, `start_pulse_o` and `tdmd_pulse_o` are high for exactly the one cycle after the clock edge that captures the commanding write. They stay low for a write that also sets STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Load select register from wdata_i[1:0] |
| data_we_i | input | 1 | Write wdata_i to the selected register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Contents of the selected register |
| init_done_i | input | 1 | Initialization complete pulse |
| rx_done_i | input | 1 | Receive complete pulse |
| tx_done_i | input | 1 | Transmit complete pulse |
| babble_i | input | 1 | Transmit babble pulse |
| cerr_i | input | 1 | Collision-test error pulse |
| miss_i | input | 1 | Missed frame pulse |
| merr_i | input | 1 | Memory error pulse |
| irq_o | output | 1 | Interrupt request |
| init_pulse_o | output | 1 | Start initialization |
| start_pulse_o | output | 1 | Start controller |
| tdmd_pulse_o | output | 1 | Transmit poll demand |
| stopped_o | output | 1 | Controller stopped |
| iblk_addr_o | output | 16+ADDR_HI_W | Initialization-block address |
| bus_cfg_o | output | 3 | Bus configuration field |

## Verification
Every register write and event pulse lands in its flop at the capturing edge. The read port is combinational over that state, so a read value, `irq_o`, `stopped_o` and a command pulse are all due at the falling edge that follows the capturing edge. A command pulse is valid only at that falling edge and is gone one cycle later. The driver therefore queues its expectations immediately after each capturing edge, and the monitor compares them at the next falling edge. Pulse checks are always queued before any select write that would take another cycle.

// File: rtl/netctl_regport_pkg.sv
package netctl_regport_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned EVT_N  = 7;
  localparam int unsigned CFG_W  = 3;

  localparam int unsigned B_INIT = 0;
  localparam int unsigned B_STRT = 1;
  localparam int unsigned B_STOP = 2;
  localparam int unsigned B_TDMD = 3;
  localparam int unsigned B_TXON = 4;
  localparam int unsigned B_RXON = 5;
  localparam int unsigned B_INEA = 6;
  localparam int unsigned B_INTR = 7;
  localparam int unsigned B_EVT0 = 8;   // flags occupy B_EVT0 .. B_EVT0+EVT_N-1
  localparam int unsigned B_ERR  = 15;

  // flag vector order, LSB first: idon, tint, rint, merr, miss, cerr, babl
  typedef logic [EVT_N-1:0] evt_t;
  localparam int unsigned F_IDON = 0;
  localparam int unsigned F_RINT = 2;
  localparam int unsigned F_MERR = 3;
  localparam int unsigned F_BABL = 6;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_AHI  = 2'd2,
    SEL_BUS  = 2'd3
  } sel_e;
endpackage

// File: rtl/netctl_status.sv
module netctl_status
  import netctl_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  evt_t              evt_i,
  output logic [DATA_W-1:0] csr_o,
  output logic              irq_o,
  output logic              stopped_o,
  output logic              init_pulse_o,
  output logic              start_pulse_o,
  output logic              tdmd_pulse_o
);
  logic stop_q, init_q, strt_q, rxon_q, txon_q, inea_q;
  logic init_p_q, strt_p_q, tdmd_p_q;
  evt_t flag_q;
  logic stop_cmd, intr, err;
  evt_t clr;

  assign stop_cmd = wr_i & wdata_i[B_STOP];
  assign clr      = wr_i ? wdata_i[B_EVT0 +: EVT_N] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b1;
      init_q <= 1'b0;
      strt_q <= 1'b0;
      rxon_q <= 1'b0;
      txon_q <= 1'b0;
      inea_q <= 1'b0;
      flag_q <= '0;
    end else if (stop_cmd) begin
      stop_q <= 1'b1;
      init_q <= 1'b0;
      strt_q <= 1'b0;
      rxon_q <= 1'b0;
      txon_q <= 1'b0;
      inea_q <= 1'b0;
      flag_q <= '0;
    end else begin
      if (wr_i) begin
        inea_q <= wdata_i[B_INEA];
        if (wdata_i[B_INIT]) begin
          init_q <= 1'b1;
          stop_q <= 1'b0;
        end
        if (wdata_i[B_STRT]) begin
          strt_q <= 1'b1;
          rxon_q <= 1'b1;
          txon_q <= 1'b1;
          stop_q <= 1'b0;
        end
      end
      // a new event beats a concurrent clear
      flag_q <= (flag_q & ~clr) | (stop_q ? '0 : evt_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_p_q <= 1'b0;
      strt_p_q <= 1'b0;
      tdmd_p_q <= 1'b0;
    end else begin
      init_p_q <= wr_i & wdata_i[B_INIT] & ~wdata_i[B_STOP];
      strt_p_q <= wr_i & wdata_i[B_STRT] & ~wdata_i[B_STOP];
      tdmd_p_q <= wr_i & wdata_i[B_TDMD] & ~wdata_i[B_STOP] & ~stop_q;
    end
  end

  assign intr = |flag_q;
  assign err  = |flag_q[F_BABL:F_MERR];

  always_comb begin
    csr_o                      = '0;
    csr_o[B_INIT]              = init_q;
    csr_o[B_STRT]              = strt_q;
    csr_o[B_STOP]              = stop_q;
    csr_o[B_TXON]              = txon_q;
    csr_o[B_RXON]              = rxon_q;
    csr_o[B_INEA]              = inea_q;
    csr_o[B_INTR]              = intr;
    csr_o[B_EVT0 +: EVT_N]     = flag_q;
    csr_o[B_ERR]               = err;
  end

  assign irq_o         = intr & inea_q;
  assign stopped_o     = stop_q;
  assign init_pulse_o  = init_p_q;
  assign start_pulse_o = strt_p_q;
  assign tdmd_pulse_o  = tdmd_p_q;

  AST_STOP_QUIETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_cmd |=> (stopped_o && !irq_o && !init_pulse_o && !start_pulse_o)) else $error("stop"); // R10
  AST_IDON_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[F_IDON] && !(wr_i && (wdata_i[B_EVT0+F_IDON] || wdata_i[B_STOP]))) |=> flag_q[F_IDON]) else $error("idon"); // R6
  AST_RINT_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_EVT0+F_RINT] && !evt_i[F_RINT]) |=> !flag_q[F_RINT]) else $error("w1c"); // R6
  AST_TDMD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdmd_pulse_o |-> $past(!stop_q && wr_i)) else $error("tdmd"); // R9
  AST_INIT_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pulse_o |-> $past(wr_i && wdata_i[B_INIT])) else $error("init pulse"); // R11
endmodule

// File: rtl/netctl_cfg.sv
module netctl_cfg
  import netctl_regport_pkg::*;
#(
  parameter int unsigned ADDR_HI_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  sel_e                  sel_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  stopped_i,
  output logic [DATA_W-1:0]     alo_o,
  output logic [ADDR_HI_W-1:0]  ahi_o,
  output logic [CFG_W-1:0]      bus_o
);
  logic open;
  assign open = we_i & stopped_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alo_o <= '0;
      ahi_o <= '0;
      bus_o <= '0;
    end else if (open) begin
      case (sel_i)
        SEL_ALO: alo_o <= wdata_i;
        SEL_AHI: ahi_o <= wdata_i[ADDR_HI_W-1:0];
        SEL_BUS: bus_o <= wdata_i[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stopped_i |=> ($stable(alo_o) && $stable(ahi_o) && $stable(bus_o))) else $error("cfg lock"); // R3
endmodule

// File: rtl/netctl_regport.sv
module netctl_regport
  import netctl_regport_pkg::*;
#(
  parameter int unsigned ADDR_HI_W = 8,
  localparam int unsigned ADDR_W   = 16 + ADDR_HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic              data_we_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              init_done_i,
  input  logic              rx_done_i,
  input  logic              tx_done_i,
  input  logic              babble_i,
  input  logic              cerr_i,
  input  logic              miss_i,
  input  logic              merr_i,
  output logic              irq_o,
  output logic              init_pulse_o,
  output logic              start_pulse_o,
  output logic              tdmd_pulse_o,
  output logic              stopped_o,
  output logic [ADDR_W-1:0] iblk_addr_o,
  output logic [2:0]        bus_cfg_o
);
  sel_e                 sel_q;
  logic                 wr_ctrl, stop_cmd;
  logic [DATA_W-1:0]    csr0, alo;
  logic [ADDR_HI_W-1:0] ahi;
  logic [CFG_W-1:0]     bus;
  evt_t                 evt;

  assign wr_ctrl  = data_we_i & (sel_q == SEL_CTRL);
  assign stop_cmd = wr_ctrl & wdata_i[B_STOP];
  assign evt      = {babble_i, cerr_i, miss_i, merr_i, rx_done_i, tx_done_i, init_done_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= SEL_CTRL;
    else if (stop_cmd) sel_q <= SEL_CTRL;
    else if (sel_we_i) sel_q <= sel_e'(wdata_i[1:0]);
  end

  netctl_status i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_ctrl),
    .wdata_i      (wdata_i),
    .evt_i        (evt),
    .csr_o        (csr0),
    .irq_o        (irq_o),
    .stopped_o    (stopped_o),
    .init_pulse_o (init_pulse_o),
    .start_pulse_o(start_pulse_o),
    .tdmd_pulse_o (tdmd_pulse_o)
  );

  netctl_cfg #(.ADDR_HI_W(ADDR_HI_W)) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (data_we_i),
    .sel_i    (sel_q),
    .wdata_i  (wdata_i),
    .stopped_i(stopped_o),
    .alo_o    (alo),
    .ahi_o    (ahi),
    .bus_o    (bus)
  );

  always_comb begin
    unique case (sel_q)
      SEL_CTRL: rdata_o = csr0;
      SEL_ALO:  rdata_o = alo;
      SEL_AHI:  rdata_o = DATA_W'(ahi);
      default:  rdata_o = DATA_W'(bus);
    endcase
  end

  assign iblk_addr_o = {ahi, alo};
  assign bus_cfg_o   = bus;

  AST_SEL_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_cmd |=> (sel_q == SEL_CTRL)) else $error("sel home"); // R10
  AST_SEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && !stop_cmd) |=> (sel_q == sel_e'($past(wdata_i[1:0])))) else $error("sel load"); // R2
endmodule

// File: tb/test_netctl_regport.sv
`timescale 1ns/1ps
module test_netctl_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0, data_we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [6:0]  ev = '0;   // {babble, cerr, miss, merr, rx, tx, init_done}
  logic        irq, init_p, start_p, tdmd_p, stopped;
  logic [23:0] iblk;
  logic [2:0]  bus;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  netctl_regport i_netctl_regport (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_we_i(sel_we), .data_we_i(data_we), .wdata_i(wdata), .rdata_o(rdata),
    .init_done_i(ev[0]), .rx_done_i(ev[2]), .tx_done_i(ev[1]),
    .babble_i(ev[6]), .cerr_i(ev[5]), .miss_i(ev[4]), .merr_i(ev[3]),
    .irq_o(irq), .init_pulse_o(init_p), .start_pulse_o(start_p), .tdmd_pulse_o(tdmd_p),
    .stopped_o(stopped), .iblk_addr_o(iblk), .bus_cfg_o(bus)
  );

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = {16'h0, rdata};
        1: act = {31'h0, irq};
        2: act = {29'h0, tdmd_p, start_p, init_p};
        3: act = {31'h0, stopped};
        4: act = {8'h0, iblk};
        default: act = {29'h0, bus};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr_sel(logic [1:0] n);
    sel_we = 1'b1; wdata = {14'h0, n};
    step();
    sel_we = 1'b0;
  endtask

  task automatic wr_data_ev(logic [15:0] v, logic [6:0] e);
    data_we = 1'b1; wdata = v; ev = e;
    step();
    data_we = 1'b0; ev = '0;
  endtask

  task automatic wr_data(logic [15:0] v);
    wr_data_ev(v, 7'h0);
  endtask

  task automatic pulse_ev(logic [6:0] e);
    ev = e;
    step();
    ev = '0;
  endtask

  task automatic rd(logic [1:0] n, logic [15:0] exp, string tag);
    wr_sel(n);
    expect_(0, {16'h0, exp}, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    expect_(0, 32'h0004, "R1 ctrl reset");
    expect_(1, 0, "R1 irq reset");
    expect_(2, 0, "R1 pulses reset");
    expect_(3, 1, "R1 stopped reset");
    expect_(4, 0, "R1 addr reset");
    expect_(5, 0, "R1 bus reset");
    step();

    // R2 R3: configuration while stopped
    wr_sel(2'd1); wr_data(16'h1234);
    wr_sel(2'd2); wr_data(16'hFFAB);
    wr_sel(2'd3); wr_data(16'hFFFF);
    rd(2'd1, 16'h1234, "R2 addr low");
    rd(2'd2, 16'h00AB, "R2 addr high");
    rd(2'd3, 16'h0007, "R2 bus field");
    expect_(4, 32'hAB1234, "R2 iblk_addr_o");
    expect_(5, 32'h7, "R2 bus_cfg_o");

    // R10: events ignored while stopped
    wr_sel(2'd0);
    pulse_ev(7'h7F);
    expect_(0, 32'h0004, "R10 events while stopped");

    // R5 R11: INIT
    wr_data(16'h0001);
    expect_(2, 32'h1, "R11 init pulse");
    expect_(3, 0, "R5 stop cleared");
    expect_(0, 32'h0001, "R5 init bit");
    step();
    expect_(2, 32'h0, "R11 pulse one cycle");

    // R3: writes blocked while running
    wr_sel(2'd1); wr_data(16'h5555);
    rd(2'd1, 16'h1234, "R3 low locked");
    expect_(4, 32'hAB1234, "R3 iblk unchanged");
    wr_sel(2'd0);

    // R5 R7: IDON without enable
    pulse_ev(7'h01);
    expect_(0, 32'h0181, "R5 idon set");
    expect_(1, 0, "R7 irq masked");

    wr_data(16'h0040);
    expect_(0, 32'h01C1, "R7 inea, idon kept");
    expect_(1, 1, "R7 irq raised");
    expect_(2, 0, "R9 zero command bits");

    wr_data(16'h0140);
    expect_(0, 32'h0041, "R6 idon w1c");
    expect_(1, 0, "R7 irq dropped");

    // R9: start and transmit demand
    wr_data(16'h0042);
    expect_(2, 32'h2, "R9 start pulse");
    expect_(0, 32'h0073, "R9 start bits");
    wr_data(16'h0048);
    expect_(2, 32'h4, "R9 tdmd pulse");
    expect_(0, 32'h0073, "R9 tdmd reads 0");

    // R8: error summary
    pulse_ev(7'h50);
    expect_(0, 32'hD0F3, "R8 babl miss err");
    expect_(1, 1, "R7 irq on error");
    wr_data(16'h4040);
    expect_(0, 32'h90F3, "R6 babl cleared R8 err kept");

    // R6: event beats concurrent clear
    wr_data_ev(16'h1440, 7'h04);
    expect_(0, 32'h04F3, "R6 rint set over clear, miss cleared");
    pulse_ev(7'h2A);
    expect_(0, 32'hAEF3, "R8 cerr merr tint");

    // R10: stop wins over same-write commands
    wr_data(16'h0047);
    expect_(0, 32'h0004, "R10 stop clears");
    expect_(1, 0, "R10 irq low");
    expect_(2, 0, "R11 no pulse with stop");
    expect_(3, 1, "R10 stopped");

    // R3: writable again
    wr_sel(2'd2); wr_data(16'h0011);
    rd(2'd2, 16'h0011, "R3 high write when stopped");
    wr_sel(2'd0);
    wr_data(16'h0008);
    expect_(2, 0, "R9 tdmd ignored when stopped");
    expect_(0, 32'h0004, "R4 ctrl map stopped");
    step();
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule